// File: doc/BRIEF.md
# Programmable FIFO Word Packer

This block gathers protocol words of a programmable bit width and builds 32-bit FIFO entries from them. A two-bit granularity setting says how many protocol words share one entry. In the 4x8 setting there are four words per entry, each in its own 8-bit slot. In the 2x16 setting there are two words, each in a 16-bit slot. In the 1x32 setting one word fills the whole entry. The words are first laid into their slots in a staging word.

Four 10-bit packing vectors then build the entry, one byte lane each. Each vector picks a bit field from the staging word. The field is set by a start bit index, a bit order and a length of one to eight bits, and the vector copies that field into its lane. A stop flag marks the last vector used for an entry. Because placement is set per lane rather than by a fixed shift, any word width up to 32 bits and either bit order can be packed.

Words arrive on a valid/ready stream, and finished entries leave on a second valid/ready stream. The vectors and the granularity come in as static configuration inputs. Software that computes and programs these values is not part of the block.

Top module: `lane_packer`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and `in_ready` is 1. A reset in the middle of an entry discards the words already collected, so the next word goes into slot 0.
- R2: Vector 0 sits in `cfg_lo[9:0]` and vector 1 in `cfg_lo[19:10]`. Vector 2 sits in `cfg_hi[9:0]` and vector 3 in `cfg_hi[19:10]`. Within a vector, bit 0 is stop, bits 3:1 are the field length minus one, bit 4 is the bit order (1 = MSB first) and bits 9:5 are the start index.
- R3: Vector i fills byte lane i (`out_entry[8i+7:8i]`). Lane bit j takes staging bit (lo+j) mod 32. For LSB-first, lo is the start index. For MSB-first, lo is the start index minus (length minus one).
- R4: Lane bits at or above the field length are 0.
- R5: `gran` 0 (4x8) takes 4 words per entry, and word k goes into staging bits [8k+7:8k]. `gran` 1 (2x16) takes 2 words, and word k goes into bits [16k+15:16k]. `gran` 2 (1x32) takes 1 word as the whole staging word. Word bits above the slot width are ignored, and no entry is offered before the last word of the entry.
- R6: `gran` 3 behaves as 1x32.
- R7: The lowest-numbered vector with stop set is the last one used. Lanes above it are 0.
- R8: If no vector has stop set, all four lanes are used.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, words offered on the input are not taken, and `out_entry` holds its value.
- R10: The entry is offered on the cycle after its last word is accepted. When `out_ready` is 1, a word can be accepted in the same cycle that the previous entry leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_lo | input | 32 | Packing vectors 0 and 1 |
| cfg_hi | input | 32 | Packing vectors 2 and 3 |
| gran | input | 2 | Words per entry: 0 = 4x8, 1 = 2x16, 2 or 3 = 1x32 |
| in_valid | input | 1 | Protocol word present |
| in_ready | output | 1 | Block takes the word this cycle |
| in_word | input | 32 | Protocol word, low-aligned in its slot |
| out_valid | output | 1 | Packed entry available |
| out_ready | input | 1 | Consumer takes the entry |
| out_entry | output | 32 | Packed FIFO entry |

## Verification
The assertions assume that `cfg_lo`, `cfg_hi` and `gran` stay fixed while an entry is being collected or is waiting. The hold and one-word properties depend on this, because a change in the configuration would legally change the extracted entry. The stimulus therefore changes the configuration only when no entry is pending and no partial entry has been collected. It also drives `in_valid` low during reset, so the past-value check on the output source sees defined values.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int LANE_W      = 8;
  localparam int NUM_LANES   = 4;
  localparam int ENTRY_W     = LANE_W * NUM_LANES;
  localparam int IDX_W       = $clog2(ENTRY_W);
  localparam int LEN_W       = $clog2(LANE_W);
  localparam int VEC_W       = IDX_W + 1 + LEN_W + 1;
  localparam int CFG_W       = 32;
  localparam int VEC_PER_CFG = 2;
  localparam int CNT_W       = $clog2(NUM_LANES);
  localparam int HW_LANES    = 2;  // byte lanes inside one 16-bit slot

  // Packed order gives start at the top and stop at bit 0.
  typedef struct packed {
    logic [IDX_W-1:0] start;
    logic             msb_first;
    logic [LEN_W-1:0] len_m1;
    logic             stop;
  } pack_vec_t;

  typedef enum logic [1:0] {
    GRAN_4X8  = 2'd0,
    GRAN_2X16 = 2'd1,
    GRAN_1X32 = 2'd2,
    GRAN_RSVD = 2'd3
  } gran_e;
endpackage

// File: rtl/lp_rst_sync.sv
module lp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lp_vec_decode.sv
module lp_vec_decode
  import lp_pkg::*;
(
  input  logic [CFG_W-1:0]     cfg_lo,
  input  logic [CFG_W-1:0]     cfg_hi,
  output pack_vec_t            vec [NUM_LANES],
  output logic [NUM_LANES-1:0] lane_en
);
  localparam int FLAT_W = 2 * CFG_W;
  localparam int USED_W = VEC_PER_CFG * VEC_W;

  logic [FLAT_W-1:0] cfg_flat;
  logic              cfg_unused;

  assign cfg_flat   = {cfg_hi, cfg_lo};
  assign cfg_unused = ^{cfg_hi[CFG_W-1:USED_W], cfg_lo[CFG_W-1:USED_W]};

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_vec
    localparam int BASE = (i / VEC_PER_CFG) * CFG_W + (i % VEC_PER_CFG) * VEC_W;
    assign vec[i] = pack_vec_t'(cfg_flat[BASE +: VEC_W]);
  end

  // A lane is active until a lower vector has raised stop.
  always_comb begin
    logic still_open;
    still_open = 1'b1;
    for (int i = 0; i < NUM_LANES; i++) begin
      lane_en[i] = still_open;
      still_open = still_open & ~vec[i].stop;
    end
  end
endmodule

// File: rtl/lp_stager.sv
module lp_stager
  import lp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         gran,
  input  logic               in_valid,
  input  logic [ENTRY_W-1:0] in_word,
  output logic               in_ready,
  input  logic               out_ready,
  output logic               full,
  output logic [ENTRY_W-1:0] stage
);
  gran_e              gran_sel;
  logic               full_q, full_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   last_idx;
  logic               accept;
  logic               last_word;

  assign gran_sel = gran_e'(gran);

  always_comb begin
    case (gran_sel)
      GRAN_4X8:  last_idx = CNT_W'(NUM_LANES - 1);
      GRAN_2X16: last_idx = CNT_W'(NUM_LANES / HW_LANES - 1);
      default:   last_idx = '0;
    endcase
  end

  assign in_ready  = ~full_q | out_ready;
  assign accept    = in_valid & in_ready;
  assign last_word = (cnt_q == last_idx);

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q & ~out_ready;
    if (accept) begin
      if (last_word) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      full_q <= full_d;
      cnt_q  <= cnt_d;
    end
  end

  // Per byte lane of the staging word: which word slot writes it and from where.
  for (genvar b = 0; b < NUM_LANES; b++) begin : g_slot
    logic              we_b;
    logic [LANE_W-1:0] dat_b;
    logic [LANE_W-1:0] byte_q;

    always_comb begin
      case (gran_sel)
        GRAN_4X8: begin
          we_b  = (cnt_q == CNT_W'(b));
          dat_b = in_word[LANE_W-1:0];
        end
        GRAN_2X16: begin
          we_b  = (cnt_q == CNT_W'(b / HW_LANES));
          dat_b = in_word[(b % HW_LANES) * LANE_W +: LANE_W];
        end
        default: begin
          we_b  = 1'b1;
          dat_b = in_word[b * LANE_W +: LANE_W];
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (accept && we_b) byte_q <= dat_b;
    end

    assign stage[b * LANE_W +: LANE_W] = byte_q;
  end

  assign full = full_q;
endmodule

// File: rtl/lp_lane_extract.sv
module lp_lane_extract
  import lp_pkg::*;
(
  input  logic [ENTRY_W-1:0] stage,
  input  pack_vec_t          vec,
  input  logic               enable,
  output logic [LANE_W-1:0]  lane
);
  logic [2*ENTRY_W-1:0] doubled;
  logic [IDX_W-1:0]     low_idx;
  logic [LANE_W-1:0]    mask;
  logic [LANE_W-1:0]    field;

  always_comb begin
    doubled = {stage, stage};
    low_idx = vec.msb_first ? (vec.start - IDX_W'(vec.len_m1)) : vec.start;
    field   = doubled[low_idx +: LANE_W];
    mask    = {LANE_W{1'b1}} >> (LEN_W'(LANE_W - 1) - vec.len_m1);
    lane    = enable ? (field & mask) : '0;
  end
endmodule

// File: rtl/lane_packer.sv
module lane_packer
  import lp_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   cfg_lo,
  input  logic [CFG_W-1:0]   cfg_hi,
  input  logic [1:0]         gran,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ENTRY_W-1:0] in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ENTRY_W-1:0] out_entry
);
  logic                 rst_sync_n;
  pack_vec_t            vec [NUM_LANES];
  logic [NUM_LANES-1:0] lane_en;
  logic [ENTRY_W-1:0]   stage;
  logic                 full;

  lp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lp_vec_decode u_dec (
    .cfg_lo  (cfg_lo),
    .cfg_hi  (cfg_hi),
    .vec     (vec),
    .lane_en (lane_en)
  );

  lp_stager u_stage (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .gran      (gran),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .full      (full),
    .stage     (stage)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    lp_lane_extract u_ext (
      .stage  (stage),
      .vec    (vec[i]),
      .enable (lane_en[i]),
      .lane   (out_entry[i * LANE_W +: LANE_W])
    );
  end

  assign out_valid = full;
endmodule

// File: rtl/lane_packer_chk.sv
module lane_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        gran_hi,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_entry,
  input logic        stop0,
  input logic [2:0]  len0
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_entry)));

  assert_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(out_valid) || $past(in_valid && in_ready)));

  assert_one_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && gran_hi) |=> out_valid);

  assert_stop_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && stop0) |-> (out_entry[31:8] == 24'd0));

  assert_len_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && len0 == 3'd0) |-> (out_entry[7:1] == 7'd0));
endmodule

bind lane_packer lane_packer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .gran_hi   (gran[1]),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_entry (out_entry),
  .stop0     (cfg_lo[0]),
  .len0      (cfg_lo[3:1])
);

// File: tb/lane_packer_test.sv
module lane_packer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_lo, cfg_hi, in_word;
  logic [1:0]  gran;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] out_entry;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lane_packer uut (
    .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .gran(gran),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_entry(out_entry)
  );

  typedef struct packed {
    logic [7:0]  tag;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [1:0]  gr;
    logic [31:0] w0, w1, w2, w3;
    logic [31:0] exp;
  } row_t;

  localparam int NROWS = 12;
  localparam row_t ROWS [NROWS] = '{
    // R3: 7-bit words, 4x8, MSB first, stop on vector 3
    '{8'd3, 32'h000770DC, 32'h000F76DC, 2'd0, 32'h55, 32'h2A, 32'h7F, 32'h01, 32'h017F2A55},
    // R4: bit 7 of each slot falls outside the 7-bit field
    '{8'd4, 32'h000770DC, 32'h000F76DC, 2'd0, 32'hFFFFFFD5, 32'hAA, 32'h0F0F0FFF, 32'h81, 32'h017F2A55},
    // R5: 15-bit words, 2x16, LSB first, upper word bits ignored
    '{8'd5, 32'h0004300E, 32'h000C360E, 2'd1, 32'hABCDFFFF, 32'hEEEE1234, 32'h0, 32'h0, 32'h12347FFF},
    // R3: 23-bit word, 1x32, MSB first, stop on vector 2
    '{8'd3, 32'h00077ADE, 32'h000000DD, 2'd2, 32'h7FABCDEF, 32'h0, 32'h0, 32'h0, 32'h006F9B57},
    // R8: no stop flag anywhere
    '{8'd8, 32'h000770DC, 32'h000F72DC, 2'd0, 32'h55, 32'h2A, 32'h7F, 32'h01, 32'h017F2A55},
    // R7: stop on vector 0 silences lanes 1..3
    '{8'd7, 32'h000770DD, 32'h000F76DC, 2'd0, 32'h55, 32'h2A, 32'h7F, 32'h01, 32'h00000055},
    // R6: reserved granularity acts as 1x32
    '{8'd6, 32'h0004380E, 32'h000C3E0E, 2'd3, 32'hCAFEF00D, 32'h0, 32'h0, 32'h0, 32'hCAFEF00D},
    // R5: 1x32 straight copy
    '{8'd5, 32'h0004380E, 32'h000C3E0E, 2'd2, 32'h13579BDF, 32'h0, 32'h0, 32'h0, 32'h13579BDF},
    // R2: full-byte MSB-first vectors in every field position
    '{8'd2, 32'h0007F8FE, 32'h000FFEFE, 2'd0, 32'h11, 32'h22, 32'h33, 32'h44, 32'h44332211},
    // R3: lane 0 pulled from slot 1
    '{8'd3, 32'h0000010F, 32'h00000000, 2'd0, 32'h11, 32'h22, 32'h33, 32'h44, 32'h00000022},
    // R3: MSB-first field wrapping below bit 0
    '{8'd3, 32'h0000005F, 32'h00000000, 2'd2, 32'h80000005, 32'h0, 32'h0, 32'h0, 32'h000000B0},
    // R4: 3-bit field
    '{8'd4, 32'h00000085, 32'h00000000, 2'd2, 32'h000000F0, 32'h0, 32'h0, 32'h0, 32'h00000007}
  };

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the word is taken.
  task automatic push(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int words_for(input logic [1:0] g);
    return (g == 2'd0) ? 4 : (g == 2'd1) ? 2 : 1;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    row_t cur;
    logic [31:0] w;
    int n;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_word = '0;
    cfg_lo = '0; cfg_hi = '0; gran = 2'd0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R1 ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R1 ready after reset", {31'd0, in_ready}, 32'd1);

    for (int r = 0; r < NROWS; r++) begin
      cur = ROWS[r];
      cfg_lo = cur.lo; cfg_hi = cur.hi; gran = cur.gr; out_ready = 1'b0;
      n = words_for(cur.gr);
      for (int k = 0; k < n; k++) begin
        case (k)
          0: w = cur.w0;
          1: w = cur.w1;
          2: w = cur.w2;
          default: w = cur.w3;
        endcase
        push(w);
        if (k < n - 1)
          check(out_valid == 1'b0, "R5 early entry", {31'd0, out_valid}, 32'd0);
      end
      check(out_valid == 1'b1, "R10 entry after last word", {31'd0, out_valid}, 32'd1);
      check(out_entry == cur.exp, $sformatf("R%0d row %0d", cur.tag, r), out_entry, cur.exp);
      @(negedge clk);
      check(out_valid && out_entry == cur.exp, "R9 hold", out_entry, cur.exp);
      check(in_ready == 1'b0, "R9 ready low when held", {31'd0, in_ready}, 32'd0);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check(out_valid == 1'b0, "R9 entry leaves", {31'd0, out_valid}, 32'd0);
    end

    // R9: a word offered while the entry waits is not taken
    cfg_lo = 32'h0004380E; cfg_hi = 32'h000C3E0E; gran = 2'd2;
    push(32'hAAAA5555);
    in_valid = 1'b1; in_word = 32'h12345678;
    check(in_ready == 1'b0, "R9 refused word", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_entry == 32'hAAAA5555, "R9 entry unchanged", out_entry, 32'hAAAA5555);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R9 refused word not queued", {31'd0, out_valid}, 32'd0);

    // R10: back-to-back words with a consumer always ready
    out_ready = 1'b1;
    in_valid = 1'b1; in_word = 32'h0BADF00D;
    @(negedge clk);
    check(out_valid && out_entry == 32'h0BADF00D, "R10 first of pair", out_entry, 32'h0BADF00D);
    in_word = 32'hFEEDBEEF;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_entry == 32'hFEEDBEEF, "R10 second of pair", out_entry, 32'hFEEDBEEF);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 pair drained", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b0;

    // R1: reset in the middle of a 4x8 entry restarts at slot 0
    cfg_lo = 32'h000770DC; cfg_hi = 32'h000F76DC; gran = 2'd0;
    push(32'h7F);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after mid reset", {31'd0, out_valid}, 32'd0);
    push(32'h55); push(32'h2A); push(32'h7F); push(32'h01);
    check(out_valid && out_entry == 32'h017F2A55, "R1 slot count restarted", out_entry, 32'h017F2A55);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule